// File: doc/BRIEF.md
# Carrier-Synchronized Data Modulator

This block builds a modulated output stream from two carrier inputs. A single modulating data bit chooses which carrier reaches the output. While the bit is 1, the output carries the high-time carrier. While it is 0, the output carries the low-time carrier. Each carrier can be inverted on its own before it is used.

When the data bit asks to leave a carrier, that carrier's sync enable decides how the switch is made. With the enable set, the switch is held back until the carrier being left (after inversion) shows a falling edge. Its last pulse is therefore never cut short. With the enable clear, the switch happens at once, and narrowed pulses may appear. If the data bit returns to the current carrier before the edge comes, the held switch is dropped.

All settings sit in one 8-bit control register that is written and read through a simple port. Both carriers and the data bit are taken to be synchronous to the system clock. The output selection is combinational from the current inputs and the registered selection state.

Top module: `carrier_modulator`

## Requirements
- R1: A write (`cfg_we`=1) stores `cfg_wdata` into the control register at the clock edge, and `cfg_rdata` shows it from the next cycle on. The field positions are: bit 5 inverts the high carrier, bit 4 enables sync on the high carrier, bit 1 inverts the low carrier, and bit 0 enables sync on the low carrier.
- R2: Bits 7, 6, 3 and 2 of the register always read 0, whatever was written (writing 8'hFF reads back 8'h33).
- R3: After reset the register reads 8'h00, and the output follows the low carrier while `mod_data` stays 0.
- R4: Once the selection has settled, `mod_out` equals the adjusted high carrier while `mod_data`=1, and equals the adjusted low carrier while `mod_data`=0.
- R5: With bit 5 set, the high carrier is inverted before use.
- R6: With bit 1 set, the low carrier is inverted before use.
- R7: With bit 4 set, a switch from high to low waits for a falling edge of the adjusted high carrier, meaning a cycle whose value is 0 where the previous cycle's value was 1. In that same cycle the output already shows the low carrier.
- R8: With bit 0 set, a switch from low to high waits in the same way for a falling edge of the adjusted low carrier.
- R9: With the sync enable of the current carrier clear, a change of `mod_data` moves the output to the other carrier in the same cycle.
- R10: If `mod_data` returns to the current carrier before the awaited edge, the held switch is cancelled and the output stays on the current carrier.
- R11: The falling edge used for sync is judged on the carrier after inversion, so with inversion on, a rising edge of the raw input releases the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| mod_data | input | 1 | Modulating data bit: 1 selects the high carrier, 0 selects the low carrier |
| carrier_hi | input | 1 | High-time carrier, raw |
| carrier_lo | input | 1 | Low-time carrier, raw |
| mod_out | output | 1 | Modulated output |

## Verification
The vector table runs with both sync enables set. It interleaves data changes with carrier steps that either do or do not form a falling edge on the carrier being left. Where a held switch and an immediate switch would give different outputs, the table tells the two apart, and one row cancels a pending switch. Directed runs then repeat the data changes with sync off, to show a switch in the same cycle, and apply each inversion alone. A final run releases a sync on a raw rising edge under inversion, which shows that edges are judged after inversion rather than on the raw pin.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

  localparam int CFG_W       = 8;
  localparam int NCAR        = 2;
  localparam int CAR_LO      = 0;
  localparam int CAR_HI      = 1;

  localparam int HI_POL_BIT  = 5;
  localparam int HI_SYNC_BIT = 4;
  localparam int LO_POL_BIT  = 1;
  localparam int LO_SYNC_BIT = 0;

  // Bits that hold state; all others read as zero.
  function automatic logic [CFG_W-1:0] cfg_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    m[HI_POL_BIT]  = 1'b1;
    m[HI_SYNC_BIT] = 1'b1;
    m[LO_POL_BIT]  = 1'b1;
    m[LO_SYNC_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic pol_apply(logic car, logic inv);
    return car ^ inv;
  endfunction

  function automatic logic fall_seen(logic prev, logic cur);
    return prev & ~cur;
  endfunction

  // Leaving a carrier is allowed when sync is off or its edge just came.
  function automatic logic may_leave(logic sync_on, logic fell);
    return ~sync_on | fell;
  endfunction

endpackage

// File: rtl/cmod_cfg_reg.sv
module cmod_cfg_reg
  import cmod_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic [NCAR-1:0] inv_en,
  output logic [NCAR-1:0] sync_en
);

  localparam logic [W-1:0] MASK = cfg_mask();

  logic [W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (cfg_we) reg_q <= cfg_wdata & MASK;
  end

  assign cfg_rdata       = reg_q;
  assign inv_en[CAR_HI]  = reg_q[HI_POL_BIT];
  assign inv_en[CAR_LO]  = reg_q[LO_POL_BIT];
  assign sync_en[CAR_HI] = reg_q[HI_SYNC_BIT];
  assign sync_en[CAR_LO] = reg_q[LO_SYNC_BIT];

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & MASK)); // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata & ~MASK) == '0); // R2

endmodule

// File: rtl/cmod_carrier_cond.sv
module cmod_carrier_cond
  import cmod_pkg::*;
#(
  parameter int N = NCAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] car_raw,
  input  logic [N-1:0] inv_en,
  output logic [N-1:0] car_adj,
  output logic [N-1:0] car_fall
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_car
    assign car_adj[g] = pol_apply(car_raw[g], inv_en[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= car_adj[g];
    end

    assign car_fall[g] = fall_seen(prev_q[g], car_adj[g]);

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      car_adj[g] |=> (car_fall[g] == !car_adj[g])); // R11
  end

endmodule

// File: rtl/cmod_sel_ctrl.sv
module cmod_sel_ctrl
  import cmod_pkg::*;
#(
  parameter int N = NCAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_data,
  input  logic [N-1:0] car_fall,
  input  logic [N-1:0] sync_en,
  output logic         sel_eff,
  output logic         sel_q
);

  logic switch_req;
  logic switch_ok;

  assign switch_req = (mod_data != sel_q);
  assign switch_ok  = switch_req & may_leave(sync_en[sel_q], car_fall[sel_q]);
  assign sel_eff    = switch_ok ? mod_data : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_eff;
  end

  AST_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && sync_en[CAR_HI] && !car_fall[CAR_HI]) |=> sel_q); // R7
  AST_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && sync_en[CAR_LO] && !car_fall[CAR_LO]) |=> !sel_q); // R8
  AST_NOSYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en[sel_q] |=> sel_q == $past(mod_data)); // R9
  AST_CANCEL_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_data == sel_q) |=> $stable(sel_q)); // R10

endmodule

// File: rtl/carrier_modulator.sv
module carrier_modulator
  import cmod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             mod_data,
  input  logic             carrier_hi,
  input  logic             carrier_lo,
  output logic             mod_out
);

  logic [NCAR-1:0] inv_en;
  logic [NCAR-1:0] sync_en;
  logic [NCAR-1:0] car_raw;
  logic [NCAR-1:0] car_adj;
  logic [NCAR-1:0] car_fall;
  logic            sel_eff;
  logic            sel_q;

  assign car_raw[CAR_HI] = carrier_hi;
  assign car_raw[CAR_LO] = carrier_lo;

  cmod_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .inv_en    (inv_en),
    .sync_en   (sync_en)
  );

  cmod_carrier_cond #(.N(NCAR)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .car_raw  (car_raw),
    .inv_en   (inv_en),
    .car_adj  (car_adj),
    .car_fall (car_fall)
  );

  cmod_sel_ctrl #(.N(NCAR)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_data (mod_data),
    .car_fall (car_fall),
    .sync_en  (sync_en),
    .sel_eff  (sel_eff),
    .sel_q    (sel_q)
  );

  assign mod_out = car_adj[sel_eff];

  AST_STEADY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == mod_data) |-> mod_out == (mod_data ? car_adj[CAR_HI] : car_adj[CAR_LO])); // R4

endmodule

// File: tb/carrier_modulator_test.sv
module carrier_modulator_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       mod_data = 1'b0;
  logic       carrier_hi = 1'b0;
  logic       carrier_lo = 1'b0;
  logic       mod_out;

  int vectors = 0;
  int miscompares = 0;

  always #(PERIOD/2) clk = ~clk;

  carrier_modulator uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .mod_data   (mod_data),
    .carrier_hi (carrier_hi),
    .carrier_lo (carrier_lo),
    .mod_out    (mod_out)
  );

  // {mod_data, carrier_hi, carrier_lo, expected mod_out}; both syncs on, no inversion
  localparam logic [3:0] VEC [9] = '{
    4'b0011,  // low selected, follow low
    4'b1111,  // want high, low has not fallen
    4'b1011,  // still waiting
    4'b1101,  // low falls: high shown now
    4'b0111,  // want low, high has not fallen
    4'b1000,  // back to high before edge: cancelled
    4'b0101,  // want low, high still up
    4'b0011,  // high falls: low shown now
    4'b0100   // steady on low
  };

  function automatic string vec_tag(int i);
    case (i)
      1, 2, 3: return "R8";
      4, 6, 7: return "R7";
      5:       return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic apply(logic m, logic h, logic l, logic exp, string tag);
    @(negedge clk);
    mod_data = m; carrier_hi = h; carrier_lo = l;
    #1;
    check(tag, {7'd0, mod_out}, {7'd0, exp});
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 5000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // reset state
    do_reset();
    #1;
    check("R3", cfg_rdata, 8'h00);
    apply(1'b0, 1'b0, 1'b1, 1'b1, "R3");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R3");

    // vector table: both syncs enabled
    mod_data = 0; carrier_hi = 0; carrier_lo = 0;
    do_reset();
    write_cfg(8'h11);
    for (int i = 0; i < 9; i++) begin
      apply(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], vec_tag(i));
    end

    // register layout and reserved bits
    write_cfg(8'hFF);
    #1 check("R2", cfg_rdata, 8'h33);
    write_cfg(8'h5A);
    #1 check("R1", cfg_rdata, 8'h12);

    // no sync: switching in the same cycle
    mod_data = 0; carrier_hi = 0; carrier_lo = 0;
    do_reset();
    apply(1'b1, 1'b1, 1'b0, 1'b1, "R9");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R9");
    apply(1'b1, 1'b0, 1'b1, 1'b0, "R4");

    // inversion of each carrier, no sync
    write_cfg(8'h22);
    apply(1'b1, 1'b0, 1'b1, 1'b1, "R5");
    apply(0, 0, 1, 0, "R6");

    // sync judged after inversion: high inverted and synced
    mod_data = 0; carrier_hi = 0; carrier_lo = 0;
    do_reset();
    write_cfg(8'h30);
    apply(1'b1, 1'b1, 1'b0, 1'b0, "R5");
    apply(1'b1, 1'b0, 1'b0, 1'b1, "R5");
    apply(1'b0, 1'b0, 1'b0, 1'b1, "R11");
    apply(1'b0, 1'b1, 1'b1, 1'b1, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule